// File: doc/BRIEF.md
# Multi-Mode Bit Counting Unit

This block is a single-stage pipelined integer bit-counting unit. Each accepted operation picks one of three counts: set-bit population, leading zeros, or the 1-based index of the lowest set bit. It also picks an operand width of 32 or 64 bits. The operand arrives with a valid strobe. The result and its valid strobe come out of registers on the next clock edge. A new operation can be issued on every cycle.

The 64-bit leading-zero and lowest-set-bit results are built from two identical 32-bit half counters, one on each half of the operand, followed by a select. The 64-bit population count adds the two half counts. All three operations share one result format: a non-negative count of at most 7 significant bits, zero-extended to 32 bits.

Top module: `bitcnt_unit`

## Requirements
- R1: Every result is a non-negative value below 128, zero-extended, so bits 31..7 of `result_o` are always zero.
- R2: With opcode 2'b00, the result is the number of set bits in the operand: the low 32 bits in 32-bit mode, all 64 bits in 64-bit mode. The maximum is 64.
- R3: With opcode 2'b01 in 32-bit mode, the result counts leading zeros of the raw bit pattern. Zero gives 32, 0xFFFFFFFF gives 0, 0x7FFFFFFF gives 1, and any other nonzero operand gives a value in 0..31.
- R4: With opcode 2'b01 in 64-bit mode, the result is the upper-half leading-zero count when the upper half is nonzero. Otherwise it is 32 plus the lower-half count, so an all-zero operand gives 64.
- R5: With opcode 2'b10 in 32-bit mode, the result is the 1-based position of the lowest set bit, and 0 for a zero operand. For example, 1 gives 1, 2 gives 2, 0x80000000 gives 32 and 0xFFFFFFFF gives 1.
- R6: With opcode 2'b10 in 64-bit mode, the lower half is examined first. If the lower half is zero, the result is 32 plus the upper-half 1-based position. If both halves are zero, the result is 0.
- R7: Opcode 2'b11 is reserved and produces a result of zero.
- R8: When `wide_i` is 0 (32-bit mode), operand bits 63..32 have no effect on the result.
- R9: `valid_o` equals `valid_i` delayed by exactly one clock, and the matching result appears in the same cycle. Back-to-back operations are accepted on every cycle, and reset clears `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select: 00 popcount, 01 leading zeros, 10 lowest set bit, 11 reserved |
| wide_i | input | 1 | 1 selects a 64-bit operand, 0 selects the low 32 bits |
| operand_i | input | 64 | Operand |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| result_o | output | 32 | Zero-extended count |

## Verification
The bench builds the unit with its default 64-bit operand width, so each half counter is 32 bits wide. This brings within reach the handover between halves:
- leading zeros moving from the upper half to the lower half;
- the lowest-set-bit search falling through an empty lower half;
- population counts at the full 64.

Operands are drawn with empty halves, single set bits and dense patterns. The 32-bit mode is driven with noise in the upper half. Valid gaps sit between back-to-back issues.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;
  typedef enum logic [1:0] {
    OP_POP  = 2'b00,
    OP_LZC  = 2'b01,
    OP_LSB  = 2'b10,
    OP_RSVD = 2'b11
  } bc_op_e;
endpackage

// File: rtl/bitcnt_half.sv
module bitcnt_half #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W) + 1,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     x_i,
  output logic [CNT_W-1:0] pop_o,
  output logic [CNT_W-1:0] lzc_o,
  output logic [IDX_W-1:0] lsb_idx_o,
  output logic             zero_o
);
  always_comb begin
    pop_o = '0;
    lzc_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      pop_o = pop_o + CNT_W'(x_i[i]);
      if (x_i[i]) lzc_o = CNT_W'(W - 1 - i);
    end
  end

  always_comb begin
    lsb_idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (x_i[i]) lsb_idx_o = IDX_W'(i);
    end
  end

  assign zero_o = ~|x_i;

  // R3
  always_comb begin
    half_zero_chk: assert ((pop_o == '0) == zero_o);
    half_lzc_chk:  assert ((lzc_o == CNT_W'(W)) == zero_o);
  end
endmodule

// File: rtl/bitcnt_merge.sv
module bitcnt_merge
  import bitcnt_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int RES_W  = 32,
  parameter int CNT_W  = $clog2(HALF_W) + 1,
  parameter int IDX_W  = $clog2(HALF_W),
  parameter int FW     = CNT_W + 1
) (
  input  logic [1:0]       op_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] pop_lo_i,
  input  logic [CNT_W-1:0] pop_hi_i,
  input  logic [CNT_W-1:0] lzc_lo_i,
  input  logic [CNT_W-1:0] lzc_hi_i,
  input  logic [IDX_W-1:0] idx_lo_i,
  input  logic [IDX_W-1:0] idx_hi_i,
  input  logic             zero_lo_i,
  input  logic             zero_hi_i,
  output logic [RES_W-1:0] res_o
);
  logic [FW-1:0] pop_f, lzc_f, lsb_f, sel_f;

  assign pop_f = FW'(pop_lo_i) + (wide_i ? FW'(pop_hi_i) : '0);

  // upper half decides unless empty
  assign lzc_f = !wide_i    ? FW'(lzc_lo_i) :
                 !zero_hi_i ? FW'(lzc_hi_i) :
                              FW'(HALF_W) + FW'(lzc_lo_i);

  // lower half decides unless empty
  assign lsb_f = !zero_lo_i             ? FW'(idx_lo_i) + FW'(1) :
                 (wide_i && !zero_hi_i) ? FW'(HALF_W) + FW'(idx_hi_i) + FW'(1) :
                                          '0;

  always_comb begin
    unique case (bc_op_e'(op_i))
      OP_POP:  sel_f = pop_f;
      OP_LZC:  sel_f = lzc_f;
      OP_LSB:  sel_f = lsb_f;
      default: sel_f = '0;
    endcase
  end

  assign res_o = RES_W'(sel_f);

  // R6
  always_comb begin
    lsb_zero_chk: assert (!(zero_lo_i && zero_hi_i) || lsb_f == '0);
  end
endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit
  import bitcnt_pkg::*;
#(
  parameter int OP_W  = 64,
  parameter int RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             wide_i,
  input  logic [OP_W-1:0]  operand_i,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  localparam int HALF_W = OP_W / 2;
  localparam int CNT_W  = $clog2(HALF_W) + 1;
  localparam int IDX_W  = $clog2(HALF_W);
  localparam int FW     = CNT_W + 1;

  logic [1:0][HALF_W-1:0] half_x;
  logic [1:0][CNT_W-1:0]  pop_h, lzc_h;
  logic [1:0][IDX_W-1:0]  idx_h;
  logic [1:0]             zero_h;
  logic [RES_W-1:0]       res_d;

  // narrow mode: upper half forced empty
  assign half_x[0] = operand_i[HALF_W-1:0];
  assign half_x[1] = wide_i ? operand_i[OP_W-1:HALF_W] : '0;

  for (genvar g = 0; g < 2; g++) begin : g_half
    bitcnt_half #(.W(HALF_W)) u_half (
      .x_i       (half_x[g]),
      .pop_o     (pop_h[g]),
      .lzc_o     (lzc_h[g]),
      .lsb_idx_o (idx_h[g]),
      .zero_o    (zero_h[g])
    );
  end

  bitcnt_merge #(.HALF_W(HALF_W), .RES_W(RES_W)) u_merge (
    .op_i      (op_i),
    .wide_i    (wide_i),
    .pop_lo_i  (pop_h[0]),
    .pop_hi_i  (pop_h[1]),
    .lzc_lo_i  (lzc_h[0]),
    .lzc_hi_i  (lzc_h[1]),
    .idx_lo_i  (idx_h[0]),
    .idx_hi_i  (idx_h[1]),
    .zero_lo_i (zero_h[0]),
    .zero_hi_i (zero_h[1]),
    .res_o     (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R1
  res_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o >> FW) == '0);

  // R7
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_RSVD) |=> result_o == '0);

  // R3
  lzc_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_LZC && !wide_i) |=> result_o <= RES_W'(HALF_W));

  // R2
  pop_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_POP) |=> result_o <= RES_W'(OP_W));
endmodule

// File: tb/sim_bitcnt_unit.sv
module sim_bitcnt_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails = 0;

  logic        pend_v = 1'b0;
  logic [31:0] pend_exp = '0;
  string       pend_tag = "R2";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitcnt_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .wide_i(wide_i), .operand_i(operand_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic int f_pop(input logic [63:0] x, input logic w);
    int n = 0;
    for (int i = 0; i < (w ? 64 : 32); i++) n += int'(x[i]);
    return n;
  endfunction

  function automatic int f_lzc(input logic [63:0] x, input logic w);
    int top = w ? 63 : 31;
    for (int i = top; i >= 0; i--) if (x[i]) return top - i;
    return top + 1;
  endfunction

  function automatic int f_lsb(input logic [63:0] x, input logic w);
    for (int i = 0; i < (w ? 64 : 32); i++) if (x[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [31:0] f_ref(input logic [1:0] op, input logic w,
                                        input logic [63:0] x);
    case (op)
      2'b00:   return 32'(f_pop(x, w));
      2'b01:   return 32'(f_lzc(x, w));
      2'b10:   return 32'(f_lsb(x, w));
      default: return 32'd0;
    endcase
  endfunction

  function automatic string f_tag(input logic [1:0] op, input logic w,
                                  input logic [63:0] x);
    if (!w && x[63:32] != 0) return "R8";
    case (op)
      2'b00:   return "R2";
      2'b01:   return w ? "R4" : "R3";
      2'b10:   return w ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    check("R9", {31'd0, valid_o}, {31'd0, pend_v});
    if (pend_v) begin
      check(pend_tag, result_o, pend_exp);
      check("R1", {7'd0, result_o[31:7]}, 32'd0);
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] op, input logic w,
                       input logic [63:0] x);
    @(negedge clk_i);
    check_out();
    valid_i   = v;
    op_i      = op;
    wide_i    = w;
    operand_i = x;
    pend_v    = v;
    pend_exp  = f_ref(op, w, x);
    pend_tag  = f_tag(op, w, x);
  endtask

  function automatic logic [63:0] rand_operand();
    logic [63:0] x;
    int k = int'($urandom_range(0, 5));
    x = {$urandom(), $urandom()};
    case (k)
      0: x = 64'd1 << $urandom_range(0, 63);
      1: x[63:32] = '0;
      2: x[31:0] = '0;
      3: x = x & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      4: x = ~(64'd1 << $urandom_range(0, 63));
      default: ;
    endcase
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;

    // R3 narrow leading zeros
    issue(1, 2'b01, 0, 64'h0);
    issue(1, 2'b01, 0, 64'hFFFF_FFFF);
    issue(1, 2'b01, 0, 64'h7FFF_FFFF);
    issue(1, 2'b01, 0, 64'h1);
    // R4 wide leading zeros
    issue(1, 2'b01, 1, 64'h0);
    issue(1, 2'b01, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1, 2'b01, 1, 64'h0000_0000_8000_0000);
    issue(1, 2'b01, 1, 64'h0000_0001_FFFF_FFFF);
    // R5 narrow lowest set bit
    issue(1, 2'b10, 0, 64'h1);
    issue(1, 2'b10, 0, 64'h2);
    issue(1, 2'b10, 0, 64'h8000_0000);
    issue(1, 2'b10, 0, 64'hFFFF_FFFF);
    issue(1, 2'b10, 0, 64'h0);
    // R6 wide lowest set bit
    issue(1, 2'b10, 1, 64'h0);
    issue(1, 2'b10, 1, 64'h0000_0001_0000_0000);
    issue(1, 2'b10, 1, 64'h8000_0000_0000_0000);
    issue(1, 2'b10, 1, 64'h8000_0000_0000_0004);
    // R2 population
    issue(1, 2'b00, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1, 2'b00, 1, 64'h0);
    // R7 reserved
    issue(1, 2'b11, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1, 2'b11, 0, 64'h1234_5678_9ABC_DEF0);
    // R8 upper noise in narrow mode
    issue(1, 2'b01, 0, 64'hFFFF_FFFF_0000_0000);
    issue(1, 2'b10, 0, 64'hDEAD_BEEF_0000_0000);
    issue(1, 2'b00, 0, 64'hFFFF_0000_0000_00F0);
    issue(0, 2'b00, 0, 64'h0);

    for (int n = 0; n < 3000; n++) begin
      logic v = ($urandom_range(0, 7) != 0);
      issue(v, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), rand_operand());
    end
    issue(0, 2'b00, 0, 64'h0);
    @(negedge clk_i);
    check_out();

    // R9 reset clears valid
    valid_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R9", {31'd0, valid_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule